// File: doc/BRIEF.md
# Display Pipeline Run and Commit Sequencer

This block is the control core of a display pipeline. It holds the software-visible control, interface-mode and interrupt registers. It also holds a bank of per-layer configuration words, each kept twice: as a shadow copy that software writes and as an active copy that the pixel pipeline reads. The block decides when the shadow set is copied into the active set, tracks whether the pipeline is running, and collects frame, tearing-effect, underflow, commit and vsync events into a maskable interrupt.

Two interface styles are supported. In continuous video mode the pipeline runs frame after frame. Software asks for a new configuration with a self-clearing update request, and the copy happens at the next end of frame. Software asks for a halt with a self-clearing stop request, which also completes at the next end of frame. In command mode the pipeline sends one frame per start. Configuration is taken only when the run bit goes from clear to set. The run bit clears itself after that frame has gone out.

Top module: `dpc_seq`

## Requirements
- R1: After reset the pipeline is stopped, the mode is video, status, enable and every layer word (shadow and active) read as zero, and irq is low.
- R2: Byte address 0x008 bit 0 selects the mode (0 video, 1 command) and reads back. Address 0x004 holds run at bit 0, stop at bit 1 and update at bit 2; a read returns running, stop pending and update pending at those bits.
- R3: Writing 1 to run while stopped starts the pipeline and copies every shadow word into the active set on the same edge. Writing 1 to run while running copies nothing.
- R4: A shadow write never changes the active set on its own. The active set changes only through a start or a committed update.
- R5: In video mode, an update request written while running stays pending until the next end of frame. At that end of frame the shadow set is copied into the active set, status bit 4 sets, and the request clears.
- R6: An update request written while stopped or in command mode is dropped: nothing becomes pending and no status bit sets.
- R7: In video mode, a stop request written while running stays pending until the next end of frame. At that end of frame the pipeline stops and status bit 0 sets. A stop written in command mode or while stopped is dropped.
- R8: In command mode, the first end of frame after a start stops the pipeline and sets status bit 0.
- R9: An end-of-frame pulse while stopped changes no state.
- R10: The tearing-effect, underflow and vsync inputs set status bits 1, 2 and 5 one cycle later, whatever the enables are. Status and enable bits 3, 6 and 7 always read 0.
- R11: Status at 0x1E8 is cleared by writing ones to 0x1E4. Writing 0xFF clears everything. An event in the same cycle as a clear of its bit wins.
- R12: irq is high exactly when some status bit and the same bit of the enable register at 0x1E0 are both set.
- R13: Layer l, word w sits at byte address 0x30 + 0x30*l + 4*w. A read at that address returns the shadow word.
- R14: A request written in the same cycle as an end-of-frame pulse waits for the following end of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| frame_end | input | 1 | One-cycle end-of-frame pulse from the timing engine |
| te_in | input | 1 | Tearing-effect event pulse |
| underflow_in | input | 1 | Pixel underflow event pulse |
| vsync_in | input | 1 | Vertical sync event pulse |
| running | output | 1 | Pipeline is running |
| irq | output | 1 | Masked interrupt request |
| layer_active | output | N_LAYERS*LAYER_WORDS*DATA_W | Active layer words, layer-major, word 0 lowest |

## Verification
The hardest cases to reach are the races between a request write and the end-of-frame pulse: a request landing on the same edge as a frame end, and a clear landing on the same edge as the event it clears. The stimulus tasks drive a register write and an event pulse in the same cycle to bring these about. The pending and status bits are then read back through the control and status registers before the next frame end. The command-mode checks rewrite the shadow words while the pipeline is running. They then confirm that the active words hold until a fresh start.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // Register byte addresses
    localparam int unsigned ADDR_CTRL    = 'h004;
    localparam int unsigned ADDR_CFG     = 'h008;
    localparam int unsigned ADDR_IEN     = 'h1E0;
    localparam int unsigned ADDR_ICLR    = 'h1E4;
    localparam int unsigned ADDR_ISTS    = 'h1E8;
    localparam int unsigned LAYER_BASE   = 'h030;
    localparam int unsigned LAYER_STRIDE = 'h030;

    // Control bit positions
    localparam int unsigned CTRL_RUN  = 0;
    localparam int unsigned CTRL_STOP = 1;
    localparam int unsigned CTRL_UPD  = 2;

    typedef enum logic {
        IF_VIDEO = 1'b0,
        IF_CMD   = 1'b1
    } if_mode_e;

    typedef struct packed {
        logic [1:0] rsvd_hi;
        logic       vsync;
        logic       upd_done;
        logic       rsvd3;
        logic       err;
        logic       te;
        logic       done;
    } irq_vec_t;

    localparam logic [7:0] IRQ_IMPL = 8'h37;

    function automatic int unsigned layer_addr(input int unsigned l, input int unsigned w);
        return LAYER_BASE + l * LAYER_STRIDE + w * 4;
    endfunction

endpackage

// File: rtl/dpc_runctl.sv
module dpc_runctl
    import dpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  if_mode_e mode,
    input  logic     ctrl_wr,
    input  logic [2:0] ctrl_bits,
    input  logic     frame_end,
    output logic     running,
    output logic     upd_pend,
    output logic     stop_pend,
    output logic     commit,
    output logic     done_evt,
    output logic     upd_evt
);
    logic start, fe_act, upd_acc, stop_acc, video;

    assign video    = (mode == IF_VIDEO);
    assign start    = ctrl_wr & ctrl_bits[CTRL_RUN] & ~running;
    assign fe_act   = frame_end & running;
    assign upd_acc  = ctrl_wr & ctrl_bits[CTRL_UPD]  & running & video;
    assign stop_acc = ctrl_wr & ctrl_bits[CTRL_STOP] & running & video;
    assign upd_evt  = fe_act & video & upd_pend;
    assign done_evt = fe_act & (~video | stop_pend);
    assign commit   = start | upd_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            upd_pend  <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (start)         running <= 1'b1;
            else if (done_evt) running <= 1'b0;
            upd_pend  <= (upd_pend  & ~fe_act) | upd_acc;
            stop_pend <= (stop_pend & ~fe_act) | stop_acc;
        end
    end
endmodule

// File: rtl/dpc_irq.sv
module dpc_irq
    import dpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_vec_t   set_ev,
    input  logic       en_wr,
    input  logic [7:0] en_data,
    input  logic       clr_wr,
    input  logic [7:0] clr_data,
    output irq_vec_t   sts,
    output logic [7:0] en,
    output logic       irq
);
    logic [7:0] clr_mask;

    assign clr_mask = clr_wr ? clr_data : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= irq_vec_t'((sts & ~clr_mask) | (set_ev & IRQ_IMPL));
            if (en_wr) en <= en_data & IRQ_IMPL;
        end
    end

    assign irq = |(sts & en);
endmodule

// File: rtl/dpc_layer_bank.sv
module dpc_layer_bank
    import dpc_pkg::*;
#(
    parameter int unsigned N_LAYERS    = 2,
    parameter int unsigned LAYER_WORDS = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    localparam int unsigned FLAT_W     = N_LAYERS * LAYER_WORDS * DATA_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output logic [FLAT_W-1:0] shadow_flat,
    output logic [FLAT_W-1:0] active_flat
);
    for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
        for (genvar w = 0; w < LAYER_WORDS; w++) begin : g_word
            localparam int unsigned IDX = l * LAYER_WORDS + w;
            localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(layer_addr(l, w));
            logic [DATA_W-1:0] sh_q, ac_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q <= '0;
                    ac_q <= '0;
                end else begin
                    if (wr_en && wr_addr == WADDR) sh_q <= wr_data;
                    if (commit) ac_q <= sh_q;
                end
            end

            assign shadow_flat[IDX*DATA_W +: DATA_W] = sh_q;
            assign active_flat[IDX*DATA_W +: DATA_W] = ac_q;
        end
    end
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
    import dpc_pkg::*;
#(
    parameter int unsigned N_LAYERS    = 2,
    parameter int unsigned LAYER_WORDS = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    localparam int unsigned FLAT_W     = N_LAYERS * LAYER_WORDS * DATA_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    input  logic              te_in,
    input  logic              underflow_in,
    input  logic              vsync_in,
    output logic              running,
    output logic              irq,
    output logic [FLAT_W-1:0] layer_active
);
    if_mode_e    mode_q;
    logic        ctrl_wr, cfg_wr, ien_wr, iclr_wr;
    logic        upd_pend, stop_pend, commit, done_evt, upd_evt;
    irq_vec_t    ev, sts;
    logic [7:0]  ien;
    logic [FLAT_W-1:0] shadow_flat;

    assign ctrl_wr = wr_en && wr_addr == ADDR_W'(ADDR_CTRL);
    assign cfg_wr  = wr_en && wr_addr == ADDR_W'(ADDR_CFG);
    assign ien_wr  = wr_en && wr_addr == ADDR_W'(ADDR_IEN);
    assign iclr_wr = wr_en && wr_addr == ADDR_W'(ADDR_ICLR);

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= IF_VIDEO;
        else if (cfg_wr) mode_q <= if_mode_e'(wr_data[0]);
    end

    dpc_runctl u_runctl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (wr_data[2:0]),
        .frame_end (frame_end),
        .running   (running),
        .upd_pend  (upd_pend),
        .stop_pend (stop_pend),
        .commit    (commit),
        .done_evt  (done_evt),
        .upd_evt   (upd_evt)
    );

    always_comb begin
        ev          = '0;
        ev.done     = done_evt;
        ev.te       = te_in;
        ev.err      = underflow_in;
        ev.upd_done = upd_evt;
        ev.vsync    = vsync_in;
    end

    dpc_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_ev   (ev),
        .en_wr    (ien_wr),
        .en_data  (wr_data[7:0]),
        .clr_wr   (iclr_wr),
        .clr_data (wr_data[7:0]),
        .sts      (sts),
        .en       (ien),
        .irq      (irq)
    );

    dpc_layer_bank #(
        .N_LAYERS    (N_LAYERS),
        .LAYER_WORDS (LAYER_WORDS),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .shadow_flat (shadow_flat),
        .active_flat (layer_active)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_CTRL))      rd_data[2:0] = {upd_pend, stop_pend, running};
        else if (rd_addr == ADDR_W'(ADDR_CFG))  rd_data[0]   = mode_q;
        else if (rd_addr == ADDR_W'(ADDR_IEN))  rd_data[7:0] = ien;
        else if (rd_addr == ADDR_W'(ADDR_ISTS)) rd_data[7:0] = sts;
        for (int unsigned l = 0; l < N_LAYERS; l++) begin
            for (int unsigned w = 0; w < LAYER_WORDS; w++) begin
                if (rd_addr == ADDR_W'(layer_addr(l, w)))
                    rd_data = shadow_flat[(l*LAYER_WORDS+w)*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/dpc_seq_chk.sv
module dpc_seq_chk
    import dpc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned ACT_W  = 256
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_bits,
    input logic              frame_end,
    input logic              te_in,
    input logic              underflow_in,
    input logic              vsync_in,
    input logic              running,
    input logic              mode,
    input logic              upd_pend,
    input logic [7:0]        sts,
    input logic [ACT_W-1:0]  layer_active
);
    logic ctrl_hit, clr_all;
    assign ctrl_hit = wr_en && wr_addr == ADDR_W'(ADDR_CTRL);
    assign clr_all  = wr_en && wr_addr == ADDR_W'(ADDR_ICLR) && wr_bits == 8'hFF;

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !(ctrl_hit && wr_bits[0])) |=> !running);

    // R8
    cmd_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (running && mode && frame_end) |=> !running);

    // R5
    upd_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_pend && running && !mode && frame_end) |=> sts[4]);

    // R14
    upd_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_pend && running && frame_end && !(ctrl_hit && wr_bits[2])) |=> !upd_pend);

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_hit && wr_bits[0] && !running) && !(upd_pend && running && !mode && frame_end))
        |=> $stable(layer_active));

    // R10
    te_capture_chk: assert property (@(posedge clk) disable iff (rst)
        te_in |=> sts[1]);

    // R11
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_all && !te_in && !underflow_in && !vsync_in && !(running && frame_end)) |=> (sts == 8'h00));

    // R7
    done_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[0]) |-> $past(frame_end && running));
endmodule

bind dpc_seq dpc_seq_chk #(
    .ADDR_W (ADDR_W),
    .ACT_W  (N_LAYERS * LAYER_WORDS * DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_bits      (wr_data[7:0]),
    .frame_end    (frame_end),
    .te_in        (te_in),
    .underflow_in (underflow_in),
    .vsync_in     (vsync_in),
    .running      (running),
    .mode         (mode_q),
    .upd_pend     (upd_pend),
    .sts          (sts),
    .layer_active (layer_active)
);

// File: tb/dpc_seq_test.sv
module dpc_seq_test;
    localparam int NL = 2;
    localparam int NW = 4;
    localparam int DW = 32;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic frame_end = 1'b0, te_in = 1'b0, underflow_in = 1'b0, vsync_in = 1'b0;
    logic running, irq;
    logic [NL*NW*DW-1:0] layer_active;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dpc_seq #(.N_LAYERS(NL), .LAYER_WORDS(NW), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .frame_end(frame_end), .te_in(te_in),
        .underflow_in(underflow_in), .vsync_in(vsync_in), .running(running),
        .irq(irq), .layer_active(layer_active)
    );

    // Behavioural reference model
    bit        m_run, m_mode, m_upd, m_stop;
    bit [7:0]  m_sts, m_en;
    bit [31:0] m_sh [NL][NW];
    bit [31:0] m_ac [NL][NW];

    function automatic int laddr(int l, int w);
        return 'h30 + 'h30 * l + 4 * w;
    endfunction

    function automatic bit [31:0] m_read(int a);
        bit [31:0] v = 0;
        if (a == 'h004) v = {29'd0, m_upd, m_stop, m_run};
        else if (a == 'h008) v = {31'd0, m_mode};
        else if (a == 'h1E0) v = {24'd0, m_en};
        else if (a == 'h1E8) v = {24'd0, m_sts};
        for (int l = 0; l < NL; l++)
            for (int w = 0; w < NW; w++)
                if (a == laddr(l, w)) v = m_sh[l][w];
        return v;
    endfunction

    function automatic bit [31:0] act_word(int l, int w);
        return layer_active[(l*NW+w)*DW +: DW];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit o_run, o_mode, o_upd, o_stop;
        bit [7:0] setm, clrm;
        if (rst) begin
            m_run = 0; m_mode = 0; m_upd = 0; m_stop = 0; m_sts = 0; m_en = 0;
            for (int l = 0; l < NL; l++)
                for (int w = 0; w < NW; w++) begin m_sh[l][w] = 0; m_ac[l][w] = 0; end
        end else begin
            o_run = m_run; o_mode = m_mode; o_upd = m_upd; o_stop = m_stop;
            setm = 0; clrm = 0;
            if (o_run && frame_end) begin
                if (!o_mode) begin
                    if (o_upd) begin m_ac = m_sh; setm[4] = 1; end
                    if (o_stop) begin m_run = 0; setm[0] = 1; end
                end else begin
                    m_run = 0; setm[0] = 1;
                end
                m_upd = 0; m_stop = 0;
            end
            if (wr_en) begin
                if (wr_addr == 'h004) begin
                    if (wr_data[0] && !o_run) begin m_run = 1; m_ac = m_sh; end
                    if (wr_data[1] && o_run && !o_mode) m_stop = 1;
                    if (wr_data[2] && o_run && !o_mode) m_upd = 1;
                end
                if (wr_addr == 'h008) m_mode = wr_data[0];
                if (wr_addr == 'h1E0) m_en = wr_data[7:0] & 8'h37;
                if (wr_addr == 'h1E4) clrm = wr_data[7:0];
                for (int l = 0; l < NL; l++)
                    for (int w = 0; w < NW; w++)
                        if (wr_addr == laddr(l, w)) m_sh[l][w] = wr_data;
            end
            if (te_in) setm[1] = 1;
            if (underflow_in) setm[2] = 1;
            if (vsync_in) setm[5] = 1;
            m_sts = (m_sts & ~clrm) | setm;
        end
        #2;
        if (!rst) begin
            chk("R8 running", {31'd0, running}, {31'd0, m_run});
            chk("R12 irq", {31'd0, irq}, {31'd0, |(m_sts & m_en)});
            chk("R13 rd_data", rd_data, m_read(rd_addr));
            for (int l = 0; l < NL; l++)
                for (int w = 0; w < NW; w++)
                    chk("R4 active", act_word(l, w), m_ac[l][w]);
        end
    end

    task automatic cyc(input bit we, input int a, input logic [31:0] d,
                       input bit fe, input bit te, input bit uf, input bit vs);
        @(negedge clk);
        wr_en = we; wr_addr = AW'(a); wr_data = d;
        frame_end = fe; te_in = te; underflow_in = uf; vsync_in = vs;
        @(negedge clk);
        wr_en = 0; frame_end = 0; te_in = 0; underflow_in = 0; vsync_in = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic fe_pulse();
        cyc(0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd('h004, v); chk("R1 ctrl after reset", v, 0);
        rd('h1E8, v); chk("R1 status after reset", v, 0);
        chk("R1 irq after reset", {31'd0, irq}, 0);
        chk("R1 active after reset", act_word(0, 0), 0);

        // R13 layer addressing, R4 shadow isolation
        wr('h030, 32'hA0A0_0001);
        wr('h06C, 32'hB0B0_0002);
        rd('h030, v); chk("R13 layer0 word0", v, 32'hA0A0_0001);
        rd('h06C, v); chk("R13 layer1 word3", v, 32'hB0B0_0002);
        chk("R4 active untouched", act_word(0, 0), 0);

        // R3 start copies shadow
        wr('h004, 1);
        chk("R3 running after start", {31'd0, running}, 1);
        chk("R3 start copies L0W0", act_word(0, 0), 32'hA0A0_0001);
        chk("R3 start copies L1W3", act_word(1, 3), 32'hB0B0_0002);

        // R5 video update commit
        wr('h030, 32'hC0C0_0003);
        wr('h004, 4);
        rd('h004, v); chk("R5 update pending", v, 5);
        chk("R4 active holds while pending", act_word(0, 0), 32'hA0A0_0001);
        fe_pulse();
        chk("R5 commit at frame end", act_word(0, 0), 32'hC0C0_0003);
        rd('h1E8, v); chk("R5 update-done status", v, 32'h10);
        rd('h004, v); chk("R5 request self-clears", v, 1);

        // R11 clear one bit
        wr('h1E4, 32'h10);
        rd('h1E8, v); chk("R11 w1c", v, 0);

        // R3 run while running copies nothing
        wr('h030, 32'hD0D0_0004);
        wr('h004, 1);
        chk("R3 no copy while running", act_word(0, 0), 32'hC0C0_0003);

        // R10 / R12 masking
        wr('h1E0, 32'h01);
        cyc(0, 0, 0, 0, 1, 0, 0);
        rd('h1E8, v); chk("R10 te status", v, 32'h02);
        chk("R12 masked irq low", {31'd0, irq}, 0);
        wr('h1E0, 32'h02);
        chk("R12 enabled irq high", {31'd0, irq}, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        rd('h1E8, v); chk("R10 underflow and vsync", v, 32'h26);
        wr('h1E4, 32'hFF);
        rd('h1E8, v); chk("R11 clear all", v, 0);
        chk("R12 irq drops", {31'd0, irq}, 0);
        wr('h1E0, 32'hFF);
        rd('h1E0, v); chk("R10 reserved enables", v, 32'h37);

        // R11 event wins over clear
        cyc(1, 'h1E4, 32'h02, 0, 1, 0, 0);
        rd('h1E8, v); chk("R11 set beats clear", v, 32'h02);
        wr('h1E4, 32'hFF);

        // R14 request on frame-end cycle waits
        cyc(1, 'h004, 4, 1, 0, 0, 0);
        rd('h004, v); chk("R14 still pending", v, 5);
        rd('h1E8, v); chk("R14 no early status", v, 0);
        fe_pulse();
        chk("R14 commits next frame", act_word(0, 0), 32'hD0D0_0004);
        wr('h1E4, 32'hFF);

        // R7 video stop
        wr('h004, 2);
        rd('h004, v); chk("R7 stop pending", v, 3);
        fe_pulse();
        chk("R7 stopped at frame end", {31'd0, running}, 0);
        rd('h1E8, v); chk("R7 done status", v, 1);

        // R6 / R9 while stopped
        wr('h004, 4);
        rd('h004, v); chk("R6 update dropped while stopped", v, 0);
        fe_pulse();
        rd('h1E8, v); chk("R9 idle frame end", v, 1);
        wr('h1E4, 32'hFF);

        // Command mode: R2, R3, R6, R7, R8
        wr('h008, 1);
        rd('h008, v); chk("R2 mode readback", v, 1);
        wr('h060, 32'hE0E0_0005);
        wr('h004, 1);
        chk("R3 cmd start copies", act_word(1, 0), 32'hE0E0_0005);
        wr('h004, 2);
        rd('h004, v); chk("R7 stop dropped in cmd", v, 1);
        wr('h004, 4);
        rd('h004, v); chk("R6 update dropped in cmd", v, 1);
        wr('h060, 32'hF0F0_0006);
        fe_pulse();
        chk("R8 run self-clears", {31'd0, running}, 0);
        rd('h1E8, v); chk("R8 done status", v, 1);
        chk("R4 cmd active holds", act_word(1, 0), 32'hE0E0_0005);
        wr('h004, 1);
        chk("R3 cmd restart copies", act_word(1, 0), 32'hF0F0_0006);
        fe_pulse();
        chk("R8 second frame stops", {31'd0, running}, 0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule